// File: doc/BRIEF.md
# Tamper Input Deglitch and Zeroize Sequencer

This block guards a secure memory subsystem against a physical tamper event. It watches an active-high tamper line, which rests low and is tied low when no sensor is fitted. It runs from a free-running slow sample clock, so it keeps working while the main system clock is stopped. The line is first synchronized. A qualification counter then measures how long the line stays high. A short glitch dies in the counter. A sustained high level starts an erase that cannot be interrupted.

The erase has three named states after `ST_IDLE`. In `ST_ERASE` the block drives a write strobe and a walking address into the key register and the vector memory, one location per sample clock, and the storage writes zero wherever the strobe is high. Key words sit at the lowest addresses and vector words follow them. In `ST_CUT` the block raises a strobe that removes the backed-up SRAM supply rail for a set number of sample clocks. In `ST_DONE` the block raises a finished flag and holds it until reset. The transitions are: IDLE to ERASE when the input qualifies, ERASE to CUT after the last address, CUT to DONE when the cut timer expires, and DONE holds. Reset returns the block to `ST_IDLE` from any state.

The qualification length is a parameter. It is chosen so that, at the configured sample rate, it falls between the width that must be rejected (about 2 µs) and the width that must always be accepted (10 µs on main power, 50 µs on backup power). The defaults assume a sample clock of about 1 MHz.

Top module: `tamper_zeroize`

## Requirements
- R1: While reset is held, and right after it is released, `wipe_we`, `rail_cut` and `wipe_done` are low and `wipe_addr` is 0.
- R2: A high level on `tamper_in` seen on QUAL_CYCLES consecutive sample edges starts the erase. `wipe_we` rises exactly SYNC_STAGES+1 edges after the edge that takes the QUAL_CYCLES-th consecutive high sample.
- R3: A high pulse seen on fewer than QUAL_CYCLES consecutive edges never starts the erase. All outputs stay at their reset values.
- R4: Any low sample restarts the qualification. Bursts of QUAL_CYCLES-1 high samples separated by single low samples never start the erase.
- R5: `wipe_we` stays high for exactly KEY_WORDS+VEC_WORDS consecutive cycles. `wipe_addr` goes 0, 1, 2 … up to the last address, one step per cycle. Addresses below KEY_WORDS select key words and the rest select vector words.
- R6: `rail_cut` rises on the cycle after the last erase write and stays high for exactly CUT_CYCLES cycles. At most one of `wipe_we`, `rail_cut` and `wipe_done` is high in any cycle.
- R7: `wipe_done` rises on the cycle after `rail_cut` falls and stays high until reset.
- R8: Once started, the sequence runs to completion whatever `tamper_in` does. Further qualified pulses while it runs or after it finishes start no second erase.
- R9: Reset asserted in the middle of the sequence returns every output to its reset value. With `tamper_in` low, the block then stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Free-running sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tamper_in | input | 1 | Tamper line, active high, asynchronous |
| wipe_we | output | 1 | Zero-write strobe to key and vector storage |
| wipe_addr | output | $clog2(KEY_WORDS+VEC_WORDS) | Storage location being cleared |
| rail_cut | output | 1 | Removes the backed-up SRAM supply while high |
| wipe_done | output | 1 | Sequence finished; sticky until reset |

## Verification
Every result is tied to the sample edge on which the QUAL_CYCLES-th consecutive high sample is taken. The write strobe starts SYNC_STAGES+1 edges later. The address advances one step per edge. The cut strobe follows the last write by one edge and lasts CUT_CYCLES edges, and the done flag follows it by one more edge. The bench drives the input on the falling edge before each sampling edge. It keeps a running count of consecutive high samples, derives the start edge from that count, and compares every output on the falling edge after each rising edge against the window the arithmetic gives for that edge. This catches any output that arrives early or late by even one cycle.

// File: rtl/tz_pkg.sv
package tz_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_CUT   = 2'd2,
        ST_DONE  = 2'd3
    } tz_state_e;

endpackage

// File: rtl/tz_sync.sv
module tz_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_s,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);

    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_s or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk_s or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign level_o = chain_q[STAGES-1];

endmodule

// File: rtl/tz_qualify.sv
module tz_qualify #(
    parameter int QUAL_CYCLES = 6
) (
    input  logic clk_s,
    input  logic rst_n,
    input  logic level_i,
    output logic qualified_o
);

    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] TERMINAL = CW'(QUAL_CYCLES);

    logic [CW-1:0] run_q;

    // Saturating run-length counter; any low sample restarts it.
    always_ff @(posedge clk_s or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!level_i) begin
            run_q <= '0;
        end else if (run_q != TERMINAL) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign qualified_o = (run_q == TERMINAL);

    // R4: a low sample always empties the run counter
    p_restart_r4: assert property (@(posedge clk_s) disable iff (!rst_n)
        !level_i |=> (run_q == '0));

    // R3: qualification is only reached after a high sample
    p_no_early_trip_r3: assert property (@(posedge clk_s) disable iff (!rst_n)
        qualified_o |-> $past(level_i));

endmodule

// File: rtl/tz_sequencer.sv
module tz_sequencer
    import tz_pkg::*;
#(
    parameter int KEY_WORDS  = 8,
    parameter int VEC_WORDS  = 16,
    parameter int CUT_CYCLES = 5,
    localparam int TOTAL     = KEY_WORDS + VEC_WORDS,
    localparam int AW        = $clog2(TOTAL)
) (
    input  logic          clk_s,
    input  logic          rst_n,
    input  logic          qualified_i,
    output logic          wipe_we,
    output logic [AW-1:0] wipe_addr,
    output logic          rail_cut,
    output logic          wipe_done
);

    localparam int CW = $clog2(CUT_CYCLES + 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'(TOTAL - 1);
    localparam logic [CW-1:0] CUT_LAST  = CW'(CUT_CYCLES - 1);

    tz_state_e     state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cut_q;

    // State register
    always_ff @(posedge clk_s or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (qualified_i)            state_d = ST_ERASE;
            ST_ERASE: if (addr_q == LAST_ADDR)    state_d = ST_CUT;
            ST_CUT:   if (cut_q == CUT_LAST)      state_d = ST_DONE;
            ST_DONE:                              state_d = ST_DONE;
        endcase
    end

    // Walking address and cut timer
    always_ff @(posedge clk_s or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cut_q  <= '0;
        end else begin
            if (state_q == ST_ERASE && addr_q != LAST_ADDR) addr_q <= addr_q + 1'b1;
            else if (state_q == ST_IDLE)                    addr_q <= '0;
            if (state_q == ST_CUT) cut_q <= cut_q + 1'b1;
            else                   cut_q <= '0;
        end
    end

    // Outputs
    always_comb begin
        wipe_we   = 1'b0;
        rail_cut  = 1'b0;
        wipe_done = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ERASE: wipe_we   = 1'b1;
            ST_CUT:   rail_cut  = 1'b1;
            ST_DONE:  wipe_done = 1'b1;
        endcase
        wipe_addr = addr_q;
    end

    p_outputs_exclusive_r6: assert property (@(posedge clk_s) disable iff (!rst_n)
        $onehot0({wipe_we, rail_cut, wipe_done}));

    p_addr_step_r5: assert property (@(posedge clk_s) disable iff (!rst_n)
        wipe_we |=> (!wipe_we || wipe_addr == $past(wipe_addr) + 1'b1));

    p_cut_after_erase_r6: assert property (@(posedge clk_s) disable iff (!rst_n)
        $rose(rail_cut) |-> ($past(wipe_we) && $past(wipe_addr) == LAST_ADDR));

    p_done_sticky_r7: assert property (@(posedge clk_s) disable iff (!rst_n)
        wipe_done |=> wipe_done);

    p_no_abort_r8: assert property (@(posedge clk_s) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/tamper_zeroize.sv
module tamper_zeroize #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 6,
    parameter int KEY_WORDS   = 8,
    parameter int VEC_WORDS   = 16,
    parameter int CUT_CYCLES  = 5,
    localparam int AW         = $clog2(KEY_WORDS + VEC_WORDS)
) (
    input  logic          clk_s,
    input  logic          rst_n,
    input  logic          tamper_in,
    output logic          wipe_we,
    output logic [AW-1:0] wipe_addr,
    output logic          rail_cut,
    output logic          wipe_done
);

    logic level;
    logic qualified;

    tz_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_s   (clk_s),
        .rst_n   (rst_n),
        .async_i (tamper_in),
        .level_o (level)
    );

    tz_qualify #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk_s       (clk_s),
        .rst_n       (rst_n),
        .level_i     (level),
        .qualified_o (qualified)
    );

    tz_sequencer #(
        .KEY_WORDS  (KEY_WORDS),
        .VEC_WORDS  (VEC_WORDS),
        .CUT_CYCLES (CUT_CYCLES)
    ) u_seq (
        .clk_s       (clk_s),
        .rst_n       (rst_n),
        .qualified_i (qualified),
        .wipe_we     (wipe_we),
        .wipe_addr   (wipe_addr),
        .rail_cut    (rail_cut),
        .wipe_done   (wipe_done)
    );

    // R2: the erase only begins one edge after the input has qualified
    p_start_r2: assert property (@(posedge clk_s) disable iff (!rst_n)
        $rose(wipe_we) |-> $past(qualified));

endmodule

// File: tb/tamper_zeroize_tb.sv
module tamper_zeroize_tb;

    localparam int SYNC  = 2;
    localparam int Q     = 6;
    localparam int KW    = 8;
    localparam int VW    = 16;
    localparam int CUTN  = 5;
    localparam int TOTAL = KW + VW;
    localparam int AW    = $clog2(TOTAL);

    logic          clk_s = 1'b0;
    logic          rst_n = 1'b0;
    logic          tamper_in = 1'b0;
    logic          wipe_we;
    logic [AW-1:0] wipe_addr;
    logic          rail_cut;
    logic          wipe_done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #10 clk_s = ~clk_s;

    tamper_zeroize #(
        .SYNC_STAGES(SYNC), .QUAL_CYCLES(Q), .KEY_WORDS(KW),
        .VEC_WORDS(VW), .CUT_CYCLES(CUTN)
    ) u_dut (
        .clk_s(clk_s), .rst_n(rst_n), .tamper_in(tamper_in),
        .wipe_we(wipe_we), .wipe_addr(wipe_addr),
        .rail_cut(rail_cut), .wipe_done(wipe_done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, "wipe_we", int'(wipe_we), 0);
        check(req, "wipe_addr", int'(wipe_addr), 0);
        check(req, "rail_cut", int'(rail_cut), 0);
        check(req, "wipe_done", int'(wipe_done), 0);
    endtask

    // R1: reset state, checked during and right after reset
    task automatic do_reset();
        @(negedge clk_s);
        tamper_in = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk_s);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk_s);
        check_idle("R1");
    endtask

    // Drive pat[k-1] before edge k, then compare outputs after edge k.
    task automatic run_pattern(input int plen, input logic [63:0] pat, input string tag);
        int  run = 0;
        bit  trig = 0;
        int  t0 = 0;
        int  window = plen + Q + TOTAL + CUTN + SYNC + 8;
        for (int k = 1; k <= window; k++) begin
            tamper_in = (k <= plen) ? pat[k-1] : 1'b0;
            @(negedge clk_s);
            run = tamper_in ? run + 1 : 0;
            if (!trig && run >= Q) begin
                trig = 1;
                t0 = k + SYNC + 1;
            end
            begin
                bit ew, ec, ed;
                ew = trig && k >= t0 && k < t0 + TOTAL;
                ec = trig && k >= t0 + TOTAL && k < t0 + TOTAL + CUTN;
                ed = trig && k >= t0 + TOTAL + CUTN;
                if (!trig) begin
                    check_idle(tag);
                end else begin
                    check(tag, "wipe_we", int'(wipe_we), int'(ew));
                    if (ew) check("R5", "wipe_addr", int'(wipe_addr), k - t0);
                    check("R6", "rail_cut", int'(rail_cut), int'(ec));
                    check("R7", "wipe_done", int'(wipe_done), int'(ed));
                end
            end
        end
        tamper_in = 1'b0;
    endtask

    initial begin
        logic [63:0] p;
        do_reset();

        // R2 / R3: sweep single pulse widths around the qualification length
        for (int n = 1; n <= Q + 3; n++) begin
            p = '0;
            for (int i = 0; i < n; i++) p[i] = 1'b1;
            do_reset();
            run_pattern(n, p, (n >= Q) ? "R2" : "R3");
        end

        // R4: bursts of Q-1 highs split by single lows never qualify
        p = '0;
        for (int b = 0; b < 5; b++)
            for (int i = 0; i < Q - 1; i++) p[b*Q + i] = 1'b1;
        do_reset();
        run_pattern(5 * Q, p, "R4");

        // R4: a short burst, one low, then a full burst qualifies on the full one
        p = '0;
        for (int i = 0; i < Q - 1; i++) p[i] = 1'b1;
        for (int i = Q; i < 2 * Q; i++) p[i] = 1'b1;
        do_reset();
        run_pattern(2 * Q, p, "R4");

        // R8: input held high throughout, and a second pulse after completion
        p = '1;
        do_reset();
        run_pattern(64, p, "R8");
        p = '0;
        for (int i = 0; i < Q; i++) p[i] = 1'b1;
        for (int i = 44; i < 44 + 2 * Q; i++) p[i] = 1'b1;
        do_reset();
        run_pattern(64, p, "R8");

        // R9: reset in the middle of the erase, then stay idle
        do_reset();
        tamper_in = 1'b1;
        repeat (Q + SYNC + 6) @(negedge clk_s);
        check("R9", "wipe_we before reset", int'(wipe_we), 1);
        tamper_in = 1'b0;
        rst_n = 1'b0;
        @(negedge clk_s);
        check_idle("R9");
        rst_n = 1'b1;
        for (int k = 0; k < TOTAL + CUTN + 10; k++) begin
            @(negedge clk_s);
            check_idle("R9");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_s);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule